// File: doc/BRIEF.md
# Chained Descriptor Copy Engine

This block copies data from card-side memory into host memory by following a chain of descriptors. Software writes the address of the first descriptor, and that write also starts the engine. Each descriptor takes three consecutive 32-bit words in memory and is read through a dedicated descriptor read port. The engine then moves the described bytes one 32-bit beat at a time: a read on the card-side port, then a write of the same word on the host-side port.

The chain ends when a descriptor marked as final has been fully copied. It also ends early on a malformed descriptor or on an error response from either data port. Every chain end updates a five-bit status register and fires a one-cycle interrupt. Software acknowledges status bits by writing ones to clear them.

Top module: `sgdma_chain_engine`

## Requirements
- R1: After reset the status register is zero, busy and the interrupt are low, and no port has a request asserted.
- R2: A start pulse while idle latches the base address. Descriptor words are read from base+0, base+4 and base+8, in that order. The next descriptor in the chain is at base+12, then base+24, and so on.
- R3: Descriptor word 0 is the card source address, word 1 is the host destination address, and bits 15:0 of word 2 are the byte count. The count is moved as count/4 beats. Beat k reads source+4k and writes the returned word to destination+4k. A beat's write completes before the next read is issued, and the descriptor port is idle while data moves.
- R4: Bit 31 of word 2 marks the final descriptor, and bits 30:16 have no effect. When a final descriptor completes, status bits 0 (reads done) and 1 (writes done) are set. In the same cycle the interrupt is high for exactly one cycle and busy is low.
- R5: A descriptor without the final mark is followed by a fetch of the next descriptor in the array, and its data is also moved.
- R6: A byte count that is zero or not a multiple of 256 sets status bit 4. No data of that descriptor is moved, the chain stops and the interrupt fires.
- R7: An error response on the card read port sets status bit 2. The failed beat is not written, the chain stops and the interrupt fires.
- R8: An error response on the host write port sets status bit 3, the chain stops and the interrupt fires.
- R9: A start pulse while busy is ignored: the running chain and its result are unchanged and no other descriptor is fetched.
- R10: A clear write resets each status bit whose mask bit is one and leaves the other bits unchanged. A mask of zero changes nothing.
- R11: When a clear write and a hardware status set fall in the same cycle, the newly set bits are kept.
- R12: On every port, a request and its address and write data stay unchanged until the cycle in which it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| base_i | input | 32 | Address of the first descriptor |
| clr_we_i | input | 1 | Status clear write strobe |
| clr_mask_i | input | 5 | Ones select the status bits to clear |
| status_o | output | 5 | Status: 0 reads done, 1 writes done, 2 read error, 3 write error, 4 descriptor error |
| busy_o | output | 1 | A chain is in progress |
| irq_o | output | 1 | One-cycle pulse when a chain ends |
| dm_req_o | output | 1 | Descriptor read request |
| dm_addr_o | output | 32 | Descriptor word address |
| dm_ack_i | input | 1 | Descriptor read acknowledge |
| dm_rdata_i | input | 32 | Descriptor word |
| rd_req_o | output | 1 | Card read request |
| rd_addr_o | output | 32 | Card read address |
| rd_ack_i | input | 1 | Card read acknowledge |
| rd_data_i | input | 32 | Card read data |
| rd_err_i | input | 1 | Card read error, valid with acknowledge |
| wr_req_o | output | 1 | Host write request |
| wr_addr_o | output | 32 | Host write address |
| wr_data_o | output | 32 | Host write data |
| wr_ack_i | input | 1 | Host write acknowledge |
| wr_err_i | input | 1 | Host write error, valid with acknowledge |

## Verification
A software clear of the status register and the hardware update at the end of a chain can land on the same clock edge. The bench provokes this by holding a clear of all five bits asserted for a whole transfer. It then requires that the cycle in which the interrupt is seen shows both completion bits set, and that the following cycle shows them cleared by the still-active clear. A start that arrives in the middle of a running chain is judged in the same way: only the first chain's fetches and writes may appear.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

   localparam int ST_W       = 5;
   localparam int ST_RD_DONE = 0;
   localparam int ST_WR_DONE = 1;
   localparam int ST_RD_ERR  = 2;
   localparam int ST_WR_ERR  = 3;
   localparam int ST_SG_ERR  = 4;

   localparam int DESC_WORDS = 3;

   typedef enum logic [1:0] {
      CS_IDLE,
      CS_FETCH,
      CS_MOVE
   } ctl_state_e;

   typedef enum logic [1:0] {
      MV_IDLE,
      MV_READ,
      MV_WRITE
   } mv_state_e;

endpackage

// File: rtl/sgdma_desc_fetch.sv
module sgdma_desc_fetch
   import sgdma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter int GRAN_LOG2 = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [AW-1:0] addr_i,
   output logic          dm_req_o,
   output logic [AW-1:0] dm_addr_o,
   input  logic          dm_ack_i,
   input  logic [DW-1:0] dm_rdata_i,
   output logic          vld_o,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic [CW-1:0] len_o,
   output logic          last_o,
   output logic          bad_o
);

   localparam int BEAT_B  = DW / 8;
   localparam int BEAT_SH = $clog2(BEAT_B);
   localparam int IDX_W   = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [AW-1:0]    base_q;
   logic             vld_q;
   logic [DW-1:0]    word_q [DESC_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         base_q   <= '0;
         vld_q    <= 1'b0;
         for (int i = 0; i < DESC_WORDS; i++) word_q[i] <= '0;
      end else begin
         vld_q <= 1'b0;
         if (go_i && !active_q) begin
            active_q <= 1'b1;
            idx_q    <= '0;
            base_q   <= addr_i;
         end else if (active_q && dm_ack_i) begin
            word_q[idx_q] <= dm_rdata_i;
            if (idx_q == IDX_LAST) begin
               active_q <= 1'b0;
               vld_q    <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end
      end
   end

   assign dm_req_o  = active_q;
   assign dm_addr_o = base_q + (AW'(idx_q) << BEAT_SH);
   assign vld_o     = vld_q;
   assign src_o     = word_q[0][AW-1:0];
   assign dst_o     = word_q[1][AW-1:0];
   assign len_o     = word_q[2][CW-1:0];
   assign last_o    = word_q[2][DW-1];

   logic unused_rsv;
   assign unused_rsv = ^word_q[2][DW-2:CW] ^ ^word_q[0] ^ ^word_q[1];

   generate
      if (GRAN_LOG2 == 0) begin : g_len_any
         assign bad_o = (len_o == '0);
      end else begin : g_len_gran
         assign bad_o = (len_o == '0) || (len_o[GRAN_LOG2-1:0] != '0);
      end
   endgenerate

   assert_desc_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      dm_req_o && !dm_ack_i |=> dm_req_o && $stable(dm_addr_o));

   assert_desc_stride_R2: assert property (@(posedge clk) disable iff (!rst_n)
      active_q && dm_ack_i && (idx_q != IDX_LAST)
      |=> dm_addr_o == $past(dm_addr_o) + AW'(BEAT_B));

endmodule

// File: rtl/sgdma_beat_mover.sv
module sgdma_beat_mover
   import sgdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic [AW-1:0] src_i,
   input  logic [AW-1:0] dst_i,
   input  logic [CW-1:0] len_i,
   output logic          rd_req_o,
   output logic [AW-1:0] rd_addr_o,
   input  logic          rd_ack_i,
   input  logic [DW-1:0] rd_data_i,
   input  logic          rd_err_i,
   output logic          wr_req_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   input  logic          wr_ack_i,
   input  logic          wr_err_i,
   output logic          done_o,
   output logic          err_rd_o,
   output logic          err_wr_o
);

   localparam int BEAT_B  = DW / 8;
   localparam int BEAT_SH = $clog2(BEAT_B);

   mv_state_e     st_q;
   logic [AW-1:0] src_q, dst_q;
   logic [CW-1:0] rem_q;
   logic [DW-1:0] data_q;
   logic          done_q, err_rd_q, err_wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= MV_IDLE;
         src_q    <= '0;
         dst_q    <= '0;
         rem_q    <= '0;
         data_q   <= '0;
         done_q   <= 1'b0;
         err_rd_q <= 1'b0;
         err_wr_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            MV_IDLE: begin
               if (go_i) begin
                  src_q    <= src_i;
                  dst_q    <= dst_i;
                  rem_q    <= len_i >> BEAT_SH;
                  err_rd_q <= 1'b0;
                  err_wr_q <= 1'b0;
                  st_q     <= MV_READ;
               end
            end
            MV_READ: begin
               if (rd_ack_i) begin
                  if (rd_err_i) begin
                     err_rd_q <= 1'b1;
                     done_q   <= 1'b1;
                     st_q     <= MV_IDLE;
                  end else begin
                     data_q <= rd_data_i;
                     st_q   <= MV_WRITE;
                  end
               end
            end
            MV_WRITE: begin
               if (wr_ack_i) begin
                  if (wr_err_i) begin
                     err_wr_q <= 1'b1;
                     done_q   <= 1'b1;
                     st_q     <= MV_IDLE;
                  end else begin
                     src_q <= src_q + AW'(BEAT_B);
                     dst_q <= dst_q + AW'(BEAT_B);
                     rem_q <= rem_q - 1'b1;
                     if (rem_q == CW'(1)) begin
                        done_q <= 1'b1;
                        st_q   <= MV_IDLE;
                     end else begin
                        st_q <= MV_READ;
                     end
                  end
               end
            end
            default: st_q <= MV_IDLE;
         endcase
      end
   end

   assign rd_req_o  = (st_q == MV_READ);
   assign rd_addr_o = src_q;
   assign wr_req_o  = (st_q == MV_WRITE);
   assign wr_addr_o = dst_q;
   assign wr_data_o = data_q;
   assign done_o    = done_q;
   assign err_rd_o  = err_rd_q;
   assign err_wr_o  = err_wr_q;

   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

   assert_wr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));

   assert_wr_after_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_req_o) |-> $past(rd_req_o && rd_ack_i && !rd_err_i));

   assert_rd_err_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_o && rd_ack_i && rd_err_i |=> !wr_req_o && !rd_req_o);

endmodule

// File: rtl/sgdma_status.sv
module sgdma_status
   import sgdma_pkg::*;
#(
   parameter int NB = ST_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_i,
   input  logic          end_i,
   input  logic          clr_we_i,
   input  logic [NB-1:0] clr_mask_i,
   output logic [NB-1:0] status_o,
   output logic          irq_o
);

   logic [NB-1:0] status_q;
   logic [NB-1:0] clr_eff;
   logic          irq_q;

   assign clr_eff = clr_we_i ? clr_mask_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         irq_q    <= 1'b0;
      end else begin
         status_q <= (status_q & ~clr_eff) | set_i;
         irq_q    <= end_i;
      end
   end

   assign status_o = status_q;
   assign irq_o    = irq_q;

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_i) |=> ((status_o & $past(set_i)) == $past(set_i)));

   assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we_i && (set_i == '0) |=> ((status_o & $past(clr_mask_i)) == '0));

   assert_irq_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

endmodule

// File: rtl/sgdma_chain_engine.sv
module sgdma_chain_engine
   import sgdma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter int GRAN_LOG2 = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic [AW-1:0]   base_i,
   input  logic            clr_we_i,
   input  logic [ST_W-1:0] clr_mask_i,
   output logic [ST_W-1:0] status_o,
   output logic            busy_o,
   output logic            irq_o,
   output logic            dm_req_o,
   output logic [AW-1:0]   dm_addr_o,
   input  logic            dm_ack_i,
   input  logic [DW-1:0]   dm_rdata_i,
   output logic            rd_req_o,
   output logic [AW-1:0]   rd_addr_o,
   input  logic            rd_ack_i,
   input  logic [DW-1:0]   rd_data_i,
   input  logic            rd_err_i,
   output logic            wr_req_o,
   output logic [AW-1:0]   wr_addr_o,
   output logic [DW-1:0]   wr_data_o,
   input  logic            wr_ack_i,
   input  logic            wr_err_i
);

   localparam int BEAT_B = DW / 8;
   localparam logic [AW-1:0] STRIDE = AW'(DESC_WORDS * BEAT_B);

   initial begin
      assert (DW % 8 == 0 && DW >= 16) else $error("data width must be whole bytes");
      assert (AW <= DW) else $error("address must fit one descriptor word");
      assert (CW < DW) else $error("count field must leave room for the final flag");
      assert (GRAN_LOG2 < CW) else $error("granule wider than count field");
      assert ((1 << GRAN_LOG2) % BEAT_B == 0 || GRAN_LOG2 == 0)
         else $error("granule must hold whole beats");
   end

   ctl_state_e    st_q;
   logic [AW-1:0] ptr_q;
   logic          fetch_go_q, mv_go_q;

   logic          desc_vld, desc_last, desc_bad;
   logic [AW-1:0] desc_src, desc_dst;
   logic [CW-1:0] desc_len;
   logic          mv_done, mv_err_rd, mv_err_wr;

   logic [ST_W-1:0] sts_set;
   logic            chain_end;

   sgdma_desc_fetch #(
      .AW(AW), .DW(DW), .CW(CW), .GRAN_LOG2(GRAN_LOG2)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_i       (fetch_go_q),
      .addr_i     (ptr_q),
      .dm_req_o   (dm_req_o),
      .dm_addr_o  (dm_addr_o),
      .dm_ack_i   (dm_ack_i),
      .dm_rdata_i (dm_rdata_i),
      .vld_o      (desc_vld),
      .src_o      (desc_src),
      .dst_o      (desc_dst),
      .len_o      (desc_len),
      .last_o     (desc_last),
      .bad_o      (desc_bad)
   );

   sgdma_beat_mover #(
      .AW(AW), .DW(DW), .CW(CW)
   ) u_mover (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (mv_go_q),
      .src_i     (desc_src),
      .dst_i     (desc_dst),
      .len_i     (desc_len),
      .rd_req_o  (rd_req_o),
      .rd_addr_o (rd_addr_o),
      .rd_ack_i  (rd_ack_i),
      .rd_data_i (rd_data_i),
      .rd_err_i  (rd_err_i),
      .wr_req_o  (wr_req_o),
      .wr_addr_o (wr_addr_o),
      .wr_data_o (wr_data_o),
      .wr_ack_i  (wr_ack_i),
      .wr_err_i  (wr_err_i),
      .done_o    (mv_done),
      .err_rd_o  (mv_err_rd),
      .err_wr_o  (mv_err_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= CS_IDLE;
         ptr_q      <= '0;
         fetch_go_q <= 1'b0;
         mv_go_q    <= 1'b0;
      end else begin
         fetch_go_q <= 1'b0;
         mv_go_q    <= 1'b0;
         case (st_q)
            CS_IDLE: begin
               if (start_i) begin
                  ptr_q      <= base_i;
                  fetch_go_q <= 1'b1;
                  st_q       <= CS_FETCH;
               end
            end
            CS_FETCH: begin
               if (desc_vld) begin
                  if (desc_bad) begin
                     st_q <= CS_IDLE;
                  end else begin
                     mv_go_q <= 1'b1;
                     st_q    <= CS_MOVE;
                  end
               end
            end
            CS_MOVE: begin
               if (mv_done) begin
                  if (mv_err_rd || mv_err_wr || desc_last) begin
                     st_q <= CS_IDLE;
                  end else begin
                     ptr_q      <= ptr_q + STRIDE;
                     fetch_go_q <= 1'b1;
                     st_q       <= CS_FETCH;
                  end
               end
            end
            default: st_q <= CS_IDLE;
         endcase
      end
   end

   always_comb begin
      sts_set   = '0;
      chain_end = 1'b0;
      if (st_q == CS_FETCH && desc_vld && desc_bad) begin
         sts_set[ST_SG_ERR] = 1'b1;
         chain_end          = 1'b1;
      end
      if (st_q == CS_MOVE && mv_done) begin
         if (mv_err_rd) begin
            sts_set[ST_RD_ERR] = 1'b1;
            chain_end          = 1'b1;
         end else if (mv_err_wr) begin
            sts_set[ST_WR_ERR] = 1'b1;
            chain_end          = 1'b1;
         end else if (desc_last) begin
            sts_set[ST_RD_DONE] = 1'b1;
            sts_set[ST_WR_DONE] = 1'b1;
            chain_end           = 1'b1;
         end
      end
   end

   sgdma_status #(.NB(ST_W)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (sts_set),
      .end_i      (chain_end),
      .clr_we_i   (clr_we_i),
      .clr_mask_i (clr_mask_i),
      .status_o   (status_o),
      .irq_o      (irq_o)
   );

   assign busy_o = (st_q != CS_IDLE);

   assert_irq_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !busy_o);

   assert_desc_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      dm_req_o |-> !rd_req_o && !wr_req_o);

   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !chain_end && !(st_q == CS_MOVE && mv_done) |=> $stable(ptr_q));

   assert_bad_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
      desc_vld && desc_bad |=> !rd_req_o && !busy_o);

endmodule

// File: tb/test_sgdma_chain_engine.sv
module test_sgdma_chain_engine;

   localparam logic [31:0] DBASE = 32'h0000_1000;
   localparam logic [31:0] KEY   = 32'h5A5A_0000;
   localparam logic [31:0] DELTA = 32'h0100_0000;
   localparam logic [31:0] SRC0  = 32'h0002_0000;

   // {reserved-bits-set, byte count, expected status, expected good writes}
   localparam logic [37:0] VEC [0:5] = '{
      {1'b0, 16'd256,  5'b00011, 16'd64},
      {1'b0, 16'd1024, 5'b00011, 16'd256},
      {1'b0, 16'd0,    5'b10000, 16'd0},
      {1'b0, 16'd300,  5'b10000, 16'd0},
      {1'b1, 16'd512,  5'b00011, 16'd128},
      {1'b1, 16'd257,  5'b10000, 16'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        start_i, clr_we_i;
   logic [31:0] base_i;
   logic [4:0]  clr_mask_i, status_o;
   logic        busy_o, irq_o;
   logic        dm_req_o, dm_ack_i;
   logic [31:0] dm_addr_o, dm_rdata_i;
   logic        rd_req_o, rd_ack_i, rd_err_i;
   logic [31:0] rd_addr_o, rd_data_i;
   logic        wr_req_o, wr_ack_i, wr_err_i;
   logic [31:0] wr_addr_o, wr_data_o;

   always #2 clk = ~clk;

   sgdma_chain_engine i_sgdma_chain_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
      .clr_we_i(clr_we_i), .clr_mask_i(clr_mask_i), .status_o(status_o),
      .busy_o(busy_o), .irq_o(irq_o),
      .dm_req_o(dm_req_o), .dm_addr_o(dm_addr_o), .dm_ack_i(dm_ack_i),
      .dm_rdata_i(dm_rdata_i),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i),
      .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
      .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .wr_ack_i(wr_ack_i), .wr_err_i(wr_err_i)
   );

   int n_cmp = 0, n_bad = 0;
   logic [31:0] dmem [0:63];
   int rd_err_at = -1, wr_err_at = -1;

   int dm_cnt = 0, rd_cnt = 0, wr_cnt = 0, good_wr = 0;
   int data_bad = 0, hold_bad = 0, overlap = 0;
   logic [31:0] dm_log [0:7];
   logic dm_seen = 1'b0, rd_seen = 1'b0, wr_seen = 1'b0;
   logic [31:0] dm_hold, rd_hold, wr_hold;

   // descriptor port responder: one waiting cycle, then acknowledge
   always @(negedge clk) begin
      if (dm_ack_i) begin
         dm_ack_i = 1'b0; dm_seen = 1'b0;
      end else if (dm_req_o) begin
         if (!dm_seen) begin
            dm_seen = 1'b1; dm_hold = dm_addr_o;
         end else begin
            if (dm_addr_o !== dm_hold) hold_bad++;
            dm_rdata_i = dmem[((dm_addr_o - DBASE) >> 2) & 32'd63];
            dm_log[dm_cnt & 7] = dm_addr_o;
            dm_cnt++;
            dm_ack_i = 1'b1;
         end
      end
      if (rd_req_o && wr_req_o) overlap++;
      if ((rd_req_o || wr_req_o) && dm_req_o) overlap++;
   end

   always @(negedge clk) begin
      if (rd_ack_i) begin
         rd_ack_i = 1'b0; rd_err_i = 1'b0; rd_seen = 1'b0;
      end else if (rd_req_o) begin
         if (!rd_seen) begin
            rd_seen = 1'b1; rd_hold = rd_addr_o;
         end else begin
            if (rd_addr_o !== rd_hold) hold_bad++;
            rd_data_i = rd_addr_o ^ KEY;
            rd_err_i  = (rd_cnt == rd_err_at);
            rd_cnt++;
            rd_ack_i = 1'b1;
         end
      end
   end

   always @(negedge clk) begin
      if (wr_ack_i) begin
         wr_ack_i = 1'b0; wr_err_i = 1'b0; wr_seen = 1'b0;
      end else if (wr_req_o) begin
         if (!wr_seen) begin
            wr_seen = 1'b1; wr_hold = wr_addr_o ^ wr_data_o;
         end else begin
            if ((wr_addr_o ^ wr_data_o) !== wr_hold) hold_bad++;
            wr_err_i = (wr_cnt == wr_err_at);
            if (!wr_err_i) begin
               good_wr++;
               if (wr_data_o !== ((wr_addr_o - DELTA) ^ KEY)) data_bad++;
            end
            wr_cnt++;
            wr_ack_i = 1'b1;
         end
      end
   end

   int b_dm, b_rd, b_wr, b_good, b_data, b_hold, b_ovl;

   task automatic snap();
      b_dm = dm_cnt; b_rd = rd_cnt; b_wr = wr_cnt; b_good = good_wr;
      b_data = data_bad; b_hold = hold_bad; b_ovl = overlap;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put_desc(input int slot, input logic [31:0] s, input logic [31:0] d,
                           input logic [31:0] ctl);
      dmem[slot*3]     = s;
      dmem[slot*3 + 1] = d;
      dmem[slot*3 + 2] = ctl;
   endtask

   task automatic kick(input logic [31:0] b);
      start_i = 1'b1; base_i = b;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   // leaves the bench on the negedge where irq is seen
   task automatic wait_irq(input string req);
      bit got = 0;
      for (int i = 0; i < 20000; i++) begin
         if (irq_o) begin got = 1; break; end
         @(negedge clk);
      end
      chk({req, " interrupt seen"}, 32'(got), 32'd1);
   endtask

   task automatic clear(input logic [4:0] m);
      clr_we_i = 1'b1; clr_mask_i = m;
      @(negedge clk);
      clr_we_i = 1'b0; clr_mask_i = '0;
   endtask

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start_i = 1'b0; base_i = '0; clr_we_i = 1'b0; clr_mask_i = '0;
      dm_ack_i = 1'b0; dm_rdata_i = '0; rd_ack_i = 1'b0; rd_data_i = '0; rd_err_i = 1'b0;
      wr_ack_i = 1'b0; wr_err_i = 1'b0;
      for (int i = 0; i < 64; i++) dmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 status", 32'(status_o), 32'd0);
      chk("R1 busy/irq", {30'd0, busy_o, irq_o}, 32'd0);
      chk("R1 requests", {29'd0, dm_req_o, rd_req_o, wr_req_o}, 32'd0);

      // vector table: one final descriptor each
      for (int v = 0; v < 6; v++) begin
         logic [31:0] ctl;
         ctl = {1'b1, VEC[v][37] ? 15'h5ABC : 15'h0, VEC[v][36:21]};
         put_desc(0, SRC0 + 32'(v) * 32'h1000, SRC0 + 32'(v) * 32'h1000 + DELTA, ctl);
         snap();
         kick(DBASE);
         wait_irq("R4");
         chk($sformatf("R4 R6 status vec%0d", v), 32'(status_o), 32'(VEC[v][20:16]));
         chk($sformatf("R4 busy at irq vec%0d", v), 32'(busy_o), 32'd0);
         chk($sformatf("R3 R6 writes vec%0d", v), 32'(good_wr - b_good), 32'(VEC[v][15:0]));
         chk($sformatf("R3 data vec%0d", v), 32'(data_bad - b_data), 32'd0);
         chk($sformatf("R3 one side at a time vec%0d", v), 32'(overlap - b_ovl), 32'd0);
         chk($sformatf("R12 held until ack vec%0d", v), 32'(hold_bad - b_hold), 32'd0);
         @(negedge clk);
         chk($sformatf("R4 irq one cycle vec%0d", v), 32'(irq_o), 32'd0);
         clear(5'h1F);
      end

      // R2 R5: two-link chain, first link not final
      put_desc(0, SRC0, SRC0 + DELTA, 32'd256);
      put_desc(1, SRC0 + 32'h4000, SRC0 + 32'h4000 + DELTA, 32'h8000_0200);
      snap();
      kick(DBASE);
      wait_irq("R5");
      chk("R5 chain writes", 32'(good_wr - b_good), 32'd192);
      chk("R5 chain status", 32'(status_o), 32'h3);
      chk("R2 fetch count", 32'(dm_cnt - b_dm), 32'd6);
      for (int k = 0; k < 6; k++)
         chk($sformatf("R2 fetch addr %0d", k), dm_log[(b_dm + k) & 7], DBASE + 32'(4 * k));
      chk("R3 data chain", 32'(data_bad - b_data), 32'd0);
      clear(5'h1F);

      // R7 read error at beat 5
      put_desc(0, SRC0, SRC0 + DELTA, 32'h8000_0100);
      snap();
      rd_err_at = b_rd + 5;
      kick(DBASE);
      wait_irq("R7");
      rd_err_at = -1;
      chk("R7 status", 32'(status_o), 32'h4);
      chk("R7 writes before error", 32'(good_wr - b_good), 32'd5);
      chk("R7 reads stop", 32'(rd_cnt - b_rd), 32'd6);
      clear(5'h1F);

      // R8 write error at beat 3
      snap();
      wr_err_at = b_wr + 3;
      kick(DBASE);
      wait_irq("R8");
      wr_err_at = -1;
      chk("R8 status", 32'(status_o), 32'h8);
      chk("R8 good writes", 32'(good_wr - b_good), 32'd3);
      chk("R8 busy", 32'(busy_o), 32'd0);
      clear(5'h1F);

      // R9 start while busy
      put_desc(0, SRC0, SRC0 + DELTA, 32'h8000_0400);
      put_desc(4, SRC0 + 32'h8000, SRC0 + 32'h8000 + DELTA, 32'h8000_0100);
      snap();
      kick(DBASE);
      repeat (40) @(negedge clk);
      kick(DBASE + 32'd48);
      wait_irq("R9");
      chk("R9 writes of first chain only", 32'(good_wr - b_good), 32'd256);
      chk("R9 fetches", 32'(dm_cnt - b_dm), 32'd3);
      chk("R9 status", 32'(status_o), 32'h3);
      @(negedge clk);

      // R10 write-one-to-clear
      clear(5'b00001);
      chk("R10 clear bit0", 32'(status_o), 32'h2);
      clear(5'b00000);
      chk("R10 zero mask", 32'(status_o), 32'h2);
      clear(5'b00010);
      chk("R10 clear bit1", 32'(status_o), 32'h0);

      // R11 clear held through the end of a chain
      put_desc(0, SRC0, SRC0 + DELTA, 32'h8000_0100);
      clr_we_i = 1'b1; clr_mask_i = 5'h1F;
      kick(DBASE);
      wait_irq("R11");
      chk("R11 set wins over clear", 32'(status_o), 32'h3);
      @(negedge clk);
      chk("R11 clear next cycle", 32'(status_o), 32'h0);
      clr_we_i = 1'b0; clr_mask_i = '0;
      @(negedge clk);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule